// File: doc/BRIEF.md
# Real-Time Clock Update Cycle Sequencer

This block paces the once-per-second advance of a real-time clock's time registers. A one-cycle `sec_tick` pulse starts an update cycle. The block first raises the busy status `uip_o` for a guard interval. It then issues a single-cycle `upd_strobe_o` that tells the external time counters to advance. The busy status stays high for the update interval. When the cycle ends, the block sets a sticky update-ended flag, which can be routed to an interrupt line.

Both intervals are counted in pulses of a fine timebase enable `base_en`. Software can therefore rely on one rule: while `uip_o` reads low, the counters will not move for at least the guard interval.

A host freeze input lets software load the time safely. While it is high, new seconds ticks are dropped, and a cycle that is still in its guard phase is abandoned before its strobe. A cycle whose strobe has already been issued always runs to completion.

Top module: `rtc_upd_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `uip_o`, `upd_strobe_o`, `upd_flag_o` and `upd_irq_o` are all 0.
- R2: When the block is idle and `sec_tick` is high with `hold_upd` low, `uip_o` rises in the next cycle. `upd_strobe_o` fires only after exactly GUARD_EN `base_en` pulses have been seen during the guard phase, in the cycle after the last of them.
- R3: `upd_strobe_o` is high for exactly one cycle per completed update, and `uip_o` is high whenever it is high.
- R4: `uip_o` stays high until UPD_EN `base_en` pulses have been counted from the strobe cycle onward. It falls in the cycle after the last of them, and in that same cycle `upd_flag_o` reads 1.
- R5: A `sec_tick` that arrives while `hold_upd` is high and the block is idle is dropped: `uip_o` stays 0 and no strobe follows.
- R6: If `hold_upd` is high during the guard phase, the cycle is abandoned: next cycle `uip_o` is 0 and no strobe is issued. During the update phase, `hold_upd` has no effect.
- R7: A `sec_tick` that arrives while a cycle is in progress (guard, update, or the one-cycle end state) is ignored and does not restart or lengthen the cycle.
- R8: `upd_flag_o` stays set until `flag_clr` is pulsed. If a clear and a new set fall in the same cycle, the flag stays set.
- R9: `upd_irq_o` is high exactly when `upd_flag_o` is 1 and `ended_ie` is 1.
- R10: Neither interval advances in a cycle where `base_en` is low: `uip_o` holds high through such cycles unless the guard phase is abandoned by `hold_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per second that requests an update |
| base_en | input | 1 | Fine timebase enable; each pulse counts one interval unit |
| hold_upd | input | 1 | Host freeze: drops ticks and abandons a guard phase |
| ended_ie | input | 1 | Routes the update-ended flag to the interrupt line |
| flag_clr | input | 1 | Clears the update-ended flag (status read side effect) |
| uip_o | output | 1 | Update-in-progress status |
| upd_strobe_o | output | 1 | One-cycle command to the time counters to advance |
| upd_flag_o | output | 1 | Sticky update-ended flag |
| upd_irq_o | output | 1 | Update-ended interrupt request |

## Verification
The bench builds the block with GUARD_EN=3 and UPD_EN=4 in place of the microsecond-scale defaults. A whole update cycle then lasts only a handful of clocks. This short window lets the bench reach several corner cases many times within one run: a freeze landing on each guard cycle, ticks colliding with every phase, and flag clears coinciding with the end of a cycle. Sparse and gapped `base_en` patterns then show that both intervals count enables rather than clocks.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GUARD  = 2'd1,
        ST_UPDATE = 2'd2,
        ST_DONE   = 2'd3
    } upd_state_e;

    typedef struct packed {
        logic busy;
        logic strobe;
        logic ended;
    } upd_evt_t;

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/rtc_upd_fsm.sv
module rtc_upd_fsm
    import rtc_upd_pkg::*;
#(
    parameter int unsigned GUARD_EN = 244,
    parameter int unsigned UPD_EN   = 248
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       en_i,
    input  logic       hold_i,
    output upd_state_e state_o,
    output upd_evt_t   evt_o
);
    localparam int unsigned CW = cnt_width(GUARD_EN, UPD_EN);
    localparam logic [CW-1:0] G_LAST = CW'(GUARD_EN - 1);
    localparam logic [CW-1:0] U_LAST = CW'(UPD_EN - 1);

    upd_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          strobe_q, strobe_d;
    logic          ended;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        strobe_d = 1'b0;
        ended    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick_i && !hold_i) begin
                    state_d = ST_GUARD;
                    cnt_d   = '0;
                end
            end
            ST_GUARD: begin
                if (hold_i) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (en_i) begin
                    if (cnt_q == G_LAST) begin
                        state_d  = ST_UPDATE;
                        cnt_d    = '0;
                        strobe_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_UPDATE: begin
                if (en_i) begin
                    if (cnt_q == U_LAST) begin
                        state_d = ST_DONE;
                        cnt_d   = '0;
                        ended   = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            strobe_q <= strobe_d;
        end
    end

    assign state_o      = state_q;
    assign evt_o.busy   = (state_q == ST_GUARD) || (state_q == ST_UPDATE);
    assign evt_o.strobe = strobe_q;
    assign evt_o.ended  = ended;

endmodule

// File: rtl/rtc_upd_flag.sv
module rtc_upd_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & ie_i;

endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq
    import rtc_upd_pkg::*;
#(
    parameter int unsigned GUARD_EN = 244,
    parameter int unsigned UPD_EN   = 248
) (
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    input  logic base_en,
    input  logic hold_upd,
    input  logic ended_ie,
    input  logic flag_clr,
    output logic uip_o,
    output logic upd_strobe_o,
    output logic upd_flag_o,
    output logic upd_irq_o
);
    upd_state_e state;
    upd_evt_t   evt;

    rtc_upd_fsm #(
        .GUARD_EN(GUARD_EN),
        .UPD_EN  (UPD_EN)
    ) fsm_i (
        .clk    (clk),
        .rst    (rst),
        .tick_i (sec_tick),
        .en_i   (base_en),
        .hold_i (hold_upd),
        .state_o(state),
        .evt_o  (evt)
    );

    rtc_upd_flag flag_i (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt.ended),
        .clr_i (flag_clr),
        .ie_i  (ended_ie),
        .flag_o(upd_flag_o),
        .irq_o (upd_irq_o)
    );

    assign uip_o        = evt.busy;
    assign upd_strobe_o = evt.strobe;

endmodule

// File: rtl/rtc_upd_seq_chk.sv
module rtc_upd_seq_chk
    import rtc_upd_pkg::*;
#(
    parameter int unsigned GUARD_EN = 244,
    parameter int unsigned UPD_EN   = 248
) (
    input logic       clk,
    input logic       rst,
    input logic       sec_tick,
    input logic       base_en,
    input logic       hold_upd,
    input logic       ended_ie,
    input logic       flag_clr,
    input logic       uip_o,
    input logic       upd_strobe_o,
    input logic       upd_flag_o,
    input logic       upd_irq_o,
    input upd_state_e st
);
    logic [15:0] g_cnt, u_cnt;

    always_ff @(posedge clk) begin
        if (rst || st == ST_IDLE) begin
            g_cnt <= '0;
            u_cnt <= '0;
        end else begin
            if (st == ST_GUARD && base_en)  g_cnt <= g_cnt + 16'd1;
            if (st == ST_UPDATE && base_en) u_cnt <= u_cnt + 16'd1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!uip_o && !upd_strobe_o && !upd_flag_o && !upd_irq_o));

    a_r2_guard_len: assert property (@(posedge clk) disable iff (rst)
        upd_strobe_o |-> (g_cnt == 16'(GUARD_EN)));

    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && sec_tick && !hold_upd) |=> uip_o);

    a_r3_one_pulse: assert property (@(posedge clk) disable iff (rst)
        upd_strobe_o |=> !upd_strobe_o);

    a_r3_strobe_busy: assert property (@(posedge clk) disable iff (rst)
        upd_strobe_o |-> uip_o);

    a_r4_update_len: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE) |-> (u_cnt == 16'(UPD_EN) && upd_flag_o && !uip_o));

    a_r5_frozen_tick: assert property (@(posedge clk) disable iff (rst)
        (!uip_o && st != ST_DONE && hold_upd) |=> !uip_o);

    a_r6_abort_guard: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GUARD && hold_upd) |=> (!uip_o && !upd_strobe_o));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (upd_flag_o && !flag_clr) |=> upd_flag_o);

    a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
        upd_irq_o |-> (upd_flag_o && ended_ie));

    a_r10_hold_no_en: assert property (@(posedge clk) disable iff (rst)
        (uip_o && !base_en && !hold_upd) |=> uip_o);

endmodule

bind rtc_upd_seq rtc_upd_seq_chk #(
    .GUARD_EN(GUARD_EN),
    .UPD_EN  (UPD_EN)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sec_tick    (sec_tick),
    .base_en     (base_en),
    .hold_upd    (hold_upd),
    .ended_ie    (ended_ie),
    .flag_clr    (flag_clr),
    .uip_o       (uip_o),
    .upd_strobe_o(upd_strobe_o),
    .upd_flag_o  (upd_flag_o),
    .upd_irq_o   (upd_irq_o),
    .st          (state)
);

// File: tb/rtc_upd_seq_tb_top.sv
module rtc_upd_seq_tb_top;
    localparam int G = 3;
    localparam int U = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sec_tick = 1'b0, base_en = 1'b0, hold_upd = 1'b0, ended_ie = 1'b0, flag_clr = 1'b0;
    logic uip_o, upd_strobe_o, upd_flag_o, upd_irq_o;

    always #2.5 clk = ~clk;

    rtc_upd_seq #(.GUARD_EN(G), .UPD_EN(U)) dut_i (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .base_en(base_en),
        .hold_upd(hold_upd), .ended_ie(ended_ie), .flag_clr(flag_clr),
        .uip_o(uip_o), .upd_strobe_o(upd_strobe_o),
        .upd_flag_o(upd_flag_o), .upd_irq_o(upd_irq_o)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;
    string req = "R1";

    // Reference: phase 0 idle, 1 guard, 2 update, 3 end; "left" = enables still owed
    int  m_phase = 0;
    int  m_left  = 0;
    bit  m_flag  = 0;
    bit  m_strobe = 0;

    always @(posedge clk) begin
        bit set_now;
        set_now = 0;
        cycles++;
        if (rst) begin
            m_phase = 0; m_left = 0; m_flag = 0; m_strobe = 0;
        end else begin
            m_strobe = 0;
            if (m_phase == 0) begin
                if (sec_tick && !hold_upd) begin m_phase = 1; m_left = G; end
            end else if (m_phase == 1) begin
                if (hold_upd) m_phase = 0;
                else if (base_en) begin
                    m_left--;
                    if (m_left == 0) begin m_phase = 2; m_left = U; m_strobe = 1; end
                end
            end else if (m_phase == 2) begin
                if (base_en) begin
                    m_left--;
                    if (m_left == 0) begin m_phase = 3; set_now = 1; end
                end
            end else begin
                m_phase = 0;
            end
            if (set_now) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk("uip", uip_o, (m_phase == 1 || m_phase == 2));
            chk("strobe", upd_strobe_o, m_strobe);
            chk("flag", upd_flag_o, m_flag);
            chk("irq R9", upd_irq_o, m_flag && ended_ie);
        end
    end

    task automatic drive(bit t, bit e, bit f, bit ie, bit c);
        @(posedge clk); #1;
        sec_tick = t; base_en = e; hold_upd = f; ended_ie = ie; flag_clr = c;
    endtask

    task automatic idle_for(int n, bit e, bit f, bit ie);
        for (int i = 0; i < n; i++) drive(0, e, f, ie, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 150000 && !finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    initial begin
        req = "R1";
        repeat (3) @(posedge clk);
        #1 rst = 0;
        idle_for(2, 1, 0, 0);
        req = "R2";                         // R3 R4 also covered here
        drive(1, 1, 0, 0, 0); idle_for(12, 1, 0, 0);
        req = "R8";
        idle_for(3, 1, 0, 0); drive(0, 1, 0, 0, 1); idle_for(2, 1, 0, 0);
        req = "R9";
        drive(1, 1, 0, 1, 0); idle_for(12, 1, 0, 1);
        drive(0, 1, 0, 0, 0); drive(0, 1, 0, 1, 1); idle_for(2, 1, 0, 1);
        req = "R10";
        drive(1, 0, 0, 0, 0);
        for (int i = 0; i < 30; i++) drive(0, (i % 3) == 2, 0, 0, 0);
        req = "R5";
        drive(1, 1, 1, 0, 0); idle_for(8, 1, 1, 0); idle_for(2, 1, 0, 0);
        req = "R6";
        for (int k = 0; k < G; k++) begin
            drive(1, 1, 0, 0, 0); idle_for(k, 1, 0, 0);
            drive(0, 1, 1, 0, 0); idle_for(6, 1, 0, 0);
        end
        drive(1, 1, 0, 0, 0); idle_for(G + 1, 1, 0, 0); idle_for(6, 1, 1, 0); idle_for(3, 1, 0, 0);
        req = "R7";
        drive(1, 1, 0, 0, 0);
        for (int i = 0; i < 10; i++) drive(1, 1, 0, 0, 0);
        idle_for(4, 1, 0, 0);
        req = "R8";
        drive(0, 1, 0, 0, 1);
        drive(1, 1, 0, 0, 0); idle_for(G + U - 1, 1, 0, 0);
        drive(0, 1, 0, 0, 1); drive(0, 1, 0, 0, 1); idle_for(3, 1, 0, 0);
        req = "R7";
        for (int i = 0; i < 5000; i++) begin
            int r;
            r = int'($urandom % 100);
            drive(r < 15, (r % 3) != 0, r > 92, r[0], (r % 11) == 0);
        end
        idle_for(3, 1, 0, 0);
        finish_run();
    end

endmodule